// File: doc/BRIEF.md
# Nonvolatile Block Program Sequencer

This block runs the write cycle for one memory block once a write command has been accepted upstream. A block is a 32-bit data word together with its write-protect (lock) bit, and it is stored as one word whose top bit is the lock. After a start strobe the sequencer waits a fixed settling delay. It then reads the target word to look at its lock bit. If the lock is clear, it performs four phases in a fixed order: an erase pulse, a read that verifies the erase, a program pulse that writes the new data and the new lock together, and a read that verifies the program. High-voltage pulse lengths are not modelled electrically. They are parameterised clock counts, and together they make up the nominal cycle time of a few milliseconds.

When the cycle finishes, the block reports the transmit behaviour the tag must take next. Block-read mode means the tag keeps sending the addressed block. Modulation defeat means the tag stays silent. A reported mode holds until a new-command strobe clears it. The memory array sees two level enables, one for erase and one for program. Reads use a request/acknowledge pair: the sequencer keeps at most one read outstanding and waits for the acknowledge for as long as it takes, which is how the array applies back-pressure. No other flow control exists at the block's edge.

Top module: `nvblk_prog_seq`

## Requirements
- R1: After reset, busy_o is 0, tx_mode_o is 0 (none), tx_blk_o is 0, and mem_rd_req_o, mem_erase_o and mem_prog_o are all 0.
- R2: A start_i that arrives while idle sets busy_o on the next edge. The first memory access is the lock-check read request, and it appears exactly START_DLY cycles after busy_o rises.
- R3: If bit 32 (the lock) of the word returned by the lock-check read is 1, the sequencer issues no erase and no program, and reports tx_mode_o = 1 (block-read) with tx_blk_o set to the addressed block.
- R4: For an unlocked block the memory operations run strictly in this order: lock read, erase, erase-verify read, program, program-verify read. No two of them overlap.
- R5: mem_erase_o stays high for exactly ERASE_CYC consecutive cycles, and mem_prog_o stays high for exactly PROG_CYC consecutive cycles.
- R6: While mem_prog_o is high, mem_wr_data_o equals {new lock, new data} as captured at start, and mem_addr_o equals the captured block address.
- R7: When both verify reads pass, tx_mode_o becomes 1 (block-read) with tx_blk_o equal to the programmed block. busy_o falls on the same edge.
- R8: If the erase-verify read returns any 1 bit, the program phase is skipped and tx_mode_o becomes 2 (modulation defeat).
- R9: If the program-verify read returns 0 at any bit that was meant to be 1, tx_mode_o becomes 2. Extra 1 bits where 0 was meant do not cause a failure.
- R10: While idle, a reported mode holds unchanged until new_cmd_i is pulsed, which sets tx_mode_o to 0. A new_cmd_i that arrives while busy has no effect.
- R11: A start_i that arrives while busy is ignored. The block, data and lock of the running cycle are kept, and no other block is touched.
- R12: From the edge after an accepted start until the final mode is reported, busy_o stays high and tx_mode_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a write cycle (single-cycle strobe) |
| blk_addr_i | input | AW | Block to program |
| blk_data_i | input | DW | New data word |
| blk_lock_i | input | 1 | New lock value |
| new_cmd_i | input | 1 | New command received; clears the reported mode |
| mem_addr_o | output | AW | Array word address |
| mem_rd_req_o | output | 1 | Read request, one cycle |
| mem_rd_ack_i | input | 1 | Read acknowledge; mem_rd_data_i is valid with it |
| mem_rd_data_i | input | DW+1 | Read word, lock in the top bit |
| mem_erase_o | output | 1 | Erase enable (level) |
| mem_prog_o | output | 1 | Program enable (level) |
| mem_wr_data_o | output | DW+1 | Word to program, lock in the top bit |
| tx_mode_o | output | 2 | 0 none, 1 block-read, 2 modulation defeat |
| tx_blk_o | output | AW | Block named by the reported mode |
| busy_o | output | 1 | Write cycle in progress |

## Verification
The bench builds the block with START_DLY=3, ERASE_CYC=5 and PROG_CYC=4, with AW=3 and DW=32. With these values a whole cycle takes a few dozen clocks, so the bench can count the exact pulse lengths and the read delay for every vector. The eight-word array model has fault modes: an erase that leaves a bit set, a program that drops a bit, and a program that adds an extra bit. These faults drive the defeat paths and the case where extra ones are tolerated. Because of the small sizes, every outcome and the handling of strobes while busy can be reached many times well inside the cycle budget.

// File: rtl/nvprog_pkg.sv
package nvprog_pkg;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_BLKRD  = 2'd1,
    MODE_DEFEAT = 2'd2
  } tx_mode_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_DELAY,
    PH_LCK_REQ,
    PH_LCK_WAIT,
    PH_ERASE,
    PH_EV_REQ,
    PH_EV_WAIT,
    PH_PROG,
    PH_PV_REQ,
    PH_PV_WAIT
  } phase_e;

  typedef enum logic {
    VK_ERASED,
    VK_WRITTEN
  } vkind_e;

endpackage

// File: rtl/nvprog_timer.sv
module nvprog_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= len_i - 1'b1;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/nvprog_verify.sv
module nvprog_verify
  import nvprog_pkg::*;
#(
  parameter int WW = 33
) (
  input  vkind_e        kind_i,
  input  logic [WW-1:0] expect_i,
  input  logic [WW-1:0] read_i,
  output logic          pass_o
);
  logic [WW-1:0] bit_ok;

  for (genvar i = 0; i < WW; i++) begin : g_bit
    // erased: every cell must read 0; written: each wanted 1 must read 1
    assign bit_ok[i] = (kind_i == VK_ERASED) ? ~read_i[i]
                                             : (~expect_i[i] | read_i[i]);
  end

  assign pass_o = &bit_ok;
endmodule

// File: rtl/nvblk_prog_seq.sv
module nvblk_prog_seq
  import nvprog_pkg::*;
#(
  parameter int AW        = 3,
  parameter int DW        = 32,
  parameter int START_DLY = 64,
  parameter int ERASE_CYC = 318,
  parameter int PROG_CYC  = 318
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] blk_addr_i,
  input  logic [DW-1:0] blk_data_i,
  input  logic          blk_lock_i,
  input  logic          new_cmd_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_req_o,
  input  logic          mem_rd_ack_i,
  input  logic [DW:0]   mem_rd_data_i,
  output logic          mem_erase_o,
  output logic          mem_prog_o,
  output logic [DW:0]   mem_wr_data_o,
  output logic [1:0]    tx_mode_o,
  output logic [AW-1:0] tx_blk_o,
  output logic          busy_o
);
  localparam int WW   = DW + 1;
  localparam int M1   = (START_DLY > ERASE_CYC) ? START_DLY : ERASE_CYC;
  localparam int MAXC = (M1 > PROG_CYC) ? M1 : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  phase_e        ph_q, ph_n;
  tx_mode_e      mode_q, fin_mode;
  logic [AW-1:0] addr_q, blk_q;
  logic [DW-1:0] data_q;
  logic          lock_q;
  logic          fin;
  logic          tmr_load, tmr_exp;
  logic [CW-1:0] tmr_len;
  vkind_e        vkind;
  logic          v_pass;

  nvprog_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expire_o (tmr_exp)
  );

  nvprog_verify #(.WW(WW)) u_vfy (
    .kind_i   (vkind),
    .expect_i ({lock_q, data_q}),
    .read_i   (mem_rd_data_i),
    .pass_o   (v_pass)
  );

  always_comb begin
    ph_n     = ph_q;
    tmr_load = 1'b0;
    tmr_len  = '0;
    fin      = 1'b0;
    fin_mode = MODE_NONE;
    vkind    = (ph_q == PH_PV_WAIT) ? VK_WRITTEN : VK_ERASED;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_n     = PH_DELAY;
        tmr_load = 1'b1;
        tmr_len  = CW'(START_DLY);
      end
      PH_DELAY:    if (tmr_exp) ph_n = PH_LCK_REQ;
      PH_LCK_REQ:  ph_n = PH_LCK_WAIT;
      PH_LCK_WAIT: if (mem_rd_ack_i) begin
        if (mem_rd_data_i[DW]) begin
          fin      = 1'b1;
          fin_mode = MODE_BLKRD;
        end else begin
          ph_n     = PH_ERASE;
          tmr_load = 1'b1;
          tmr_len  = CW'(ERASE_CYC);
        end
      end
      PH_ERASE:    if (tmr_exp) ph_n = PH_EV_REQ;
      PH_EV_REQ:   ph_n = PH_EV_WAIT;
      PH_EV_WAIT:  if (mem_rd_ack_i) begin
        if (v_pass) begin
          ph_n     = PH_PROG;
          tmr_load = 1'b1;
          tmr_len  = CW'(PROG_CYC);
        end else begin
          fin      = 1'b1;
          fin_mode = MODE_DEFEAT;
        end
      end
      PH_PROG:     if (tmr_exp) ph_n = PH_PV_REQ;
      PH_PV_REQ:   ph_n = PH_PV_WAIT;
      PH_PV_WAIT:  if (mem_rd_ack_i) begin
        fin      = 1'b1;
        fin_mode = v_pass ? MODE_BLKRD : MODE_DEFEAT;
      end
      default:     ph_n = PH_IDLE;
    endcase
    if (fin) ph_n = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      mode_q <= MODE_NONE;
      blk_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      lock_q <= 1'b0;
    end else begin
      ph_q <= ph_n;
      if (ph_q == PH_IDLE) begin
        if (start_i) begin
          addr_q <= blk_addr_i;
          data_q <= blk_data_i;
          lock_q <= blk_lock_i;
          mode_q <= MODE_NONE;
        end else if (new_cmd_i) begin
          mode_q <= MODE_NONE;
        end
      end
      if (fin) begin
        mode_q <= fin_mode;
        blk_q  <= addr_q;
      end
    end
  end

  assign busy_o        = (ph_q != PH_IDLE);
  assign mem_addr_o    = addr_q;
  assign mem_wr_data_o = {lock_q, data_q};
  assign mem_rd_req_o  = (ph_q == PH_LCK_REQ) || (ph_q == PH_EV_REQ) || (ph_q == PH_PV_REQ);
  assign mem_erase_o   = (ph_q == PH_ERASE);
  assign mem_prog_o    = (ph_q == PH_PROG);
  assign tx_mode_o     = mode_q;
  assign tx_blk_o      = blk_q;
endmodule

// File: rtl/nvprog_chk.sv
module nvprog_chk #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          new_cmd_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rd_req_o,
  input logic          mem_erase_o,
  input logic          mem_prog_o,
  input logic [DW:0]   mem_wr_data_o,
  input logic [1:0]    tx_mode_o,
  input logic          busy_o
);
  assert_ops_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_erase_o && mem_prog_o) && !(mem_rd_req_o && (mem_erase_o || mem_prog_o)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_erase_o && !mem_prog_o && !mem_rd_req_o));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  assert_mode_none_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (tx_mode_o == 2'd0));

  assert_final_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (tx_mode_o != 2'd0));

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i && !new_cmd_i) |=> $stable(tx_mode_o));

  assert_mode_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && new_cmd_i) |=> (tx_mode_o == 2'd0));

  assert_addr_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));

  assert_wdata_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_prog_o && $past(mem_prog_o)) |-> $stable(mem_wr_data_o));
endmodule

bind nvblk_prog_seq nvprog_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .new_cmd_i     (new_cmd_i),
  .mem_addr_o    (mem_addr_o),
  .mem_rd_req_o  (mem_rd_req_o),
  .mem_erase_o   (mem_erase_o),
  .mem_prog_o    (mem_prog_o),
  .mem_wr_data_o (mem_wr_data_o),
  .tx_mode_o     (tx_mode_o),
  .busy_o        (busy_o)
);

// File: tb/sim_nvblk_prog_seq.sv
module sim_nvblk_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int SD = 3;
  localparam int EC = 5;
  localparam int PC = 4;
  localparam logic [DW-1:0] OLD = 32'h5A5A_C3C3;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          lock;
    logic          pre_lock;
    logic [1:0]    fault;   // 0 none, 1 erase stuck, 2 prog drops bit31, 3 prog adds bit0
    logic [1:0]    exp_mode;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 32'h8000_0001, 1'b0, 1'b0, 2'd0, 2'd1},
    '{3'd5, 32'hDEAD_BEEF, 1'b1, 1'b0, 2'd0, 2'd1},
    '{3'd1, 32'h1234_5678, 1'b0, 1'b1, 2'd0, 2'd1},
    '{3'd7, 32'hFFFF_0000, 1'b0, 1'b0, 2'd1, 2'd2},
    '{3'd3, 32'h8765_4321, 1'b0, 1'b0, 2'd2, 2'd2},
    '{3'd0, 32'h0000_0000, 1'b0, 1'b0, 2'd3, 2'd1},
    '{3'd4, 32'hFFFF_FFFF, 1'b1, 1'b0, 2'd0, 2'd1},
    '{3'd6, 32'h8000_0000, 1'b1, 1'b1, 2'd2, 2'd1}
  };

  logic clk = 0, rst_n = 0;
  logic start_i = 0, blk_lock_i = 0, new_cmd_i = 0;
  logic [AW-1:0] blk_addr_i = '0;
  logic [DW-1:0] blk_data_i = '0;
  logic [AW-1:0] mem_addr_o, tx_blk_o;
  logic mem_rd_req_o, mem_erase_o, mem_prog_o, busy_o;
  logic mem_rd_ack_i = 0;
  logic [DW:0] mem_rd_data_i = '0;
  logic [DW:0] mem_wr_data_o;
  logic [1:0] tx_mode_o;

  logic [DW:0] mem [0:(1<<AW)-1];
  logic [1:0]  fault = 0;
  logic [1:0]  lat = 0;
  int total = 0, fails = 0, cyc = 0;
  int w_first_req, w_erase, w_prog, w_reads, w_wd_bad, w_mode_bad;

  nvblk_prog_seq #(.AW(AW), .DW(DW), .START_DLY(SD), .ERASE_CYC(EC), .PROG_CYC(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_addr_i(blk_addr_i),
    .blk_data_i(blk_data_i), .blk_lock_i(blk_lock_i), .new_cmd_i(new_cmd_i),
    .mem_addr_o(mem_addr_o), .mem_rd_req_o(mem_rd_req_o), .mem_rd_ack_i(mem_rd_ack_i),
    .mem_rd_data_i(mem_rd_data_i), .mem_erase_o(mem_erase_o), .mem_prog_o(mem_prog_o),
    .mem_wr_data_o(mem_wr_data_o), .tx_mode_o(tx_mode_o), .tx_blk_o(tx_blk_o),
    .busy_o(busy_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // array model: two-cycle read latency, erase/program applied per enabled cycle
  always @(posedge clk) begin
    mem_rd_ack_i <= 1'b0;
    if (mem_rd_req_o && lat == 0) lat <= 2'd2;
    else if (lat != 0) begin
      lat <= lat - 1'b1;
      if (lat == 2'd1) begin
        mem_rd_ack_i  <= 1'b1;
        mem_rd_data_i <= mem[mem_addr_o];
      end
    end
    if (mem_erase_o) mem[mem_addr_o] <= (fault == 2'd1) ? 33'h20 : 33'h0;
    if (mem_prog_o) begin
      logic [DW:0] w;
      w = mem[mem_addr_o] | mem_wr_data_o;
      if (fault == 2'd2) w[31] = 1'b0;
      if (fault == 2'd3) w[0]  = 1'b1;
      mem[mem_addr_o] <= w;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic l);
    @(negedge clk);
    start_i = 1; blk_addr_i = a; blk_data_i = d; blk_lock_i = l;
    @(negedge clk);
    start_i = 0;
  endtask

  // observe one cycle from the negedge after the start edge until busy falls
  task automatic watch(input logic [DW:0] exp_wd);
    int n = 0;
    w_first_req = -1; w_erase = 0; w_prog = 0; w_reads = 0; w_wd_bad = 0; w_mode_bad = 0;
    while (busy_o && n < 1000) begin
      if (mem_rd_req_o) begin
        if (w_first_req < 0) w_first_req = n;
        w_reads++;
      end
      if (mem_erase_o) w_erase++;
      if (mem_prog_o) begin
        w_prog++;
        if (mem_wr_data_o != exp_wd) w_wd_bad++;
      end
      if (tx_mode_o != 2'd0) w_mode_bad++;
      n++;
      @(negedge clk);
    end
    chk(n < 1000, "R12 cycle ends", n, 1000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = {1'b0, OLD};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 0 && tx_mode_o == 0 && tx_blk_o == 0, "R1 reset outputs",
        {busy_o, tx_mode_o, tx_blk_o}, 0);
    chk(!mem_rd_req_o && !mem_erase_o && !mem_prog_o, "R1 memory strobes",
        {mem_rd_req_o, mem_erase_o, mem_prog_o}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      logic [DW:0] exp_mem;
      bit locked = t.pre_lock;
      mem[t.addr] = {t.pre_lock, OLD};
      fault = t.fault;
      do_start(t.addr, t.data, t.lock);
      chk(busy_o == 1, "R2 busy after start", busy_o, 1);
      watch({t.lock, t.data});
      chk(w_first_req == SD, "R2 start delay", w_first_req, SD);
      chk(w_mode_bad == 0, "R12 mode none while busy", w_mode_bad, 0);
      chk(tx_mode_o == t.exp_mode, "R7 R8 R9 final mode", tx_mode_o, t.exp_mode);
      chk(tx_blk_o == t.addr, "R3 R7 reported block", tx_blk_o, t.addr);
      if (locked) begin
        chk(w_erase == 0 && w_prog == 0, "R3 locked no erase/program", {w_erase, w_prog}, 0);
        chk(w_reads == 1, "R3 single lock read", w_reads, 1);
        exp_mem = {1'b1, OLD};
      end else if (t.fault == 2'd1) begin
        chk(w_erase == EC, "R5 erase length", w_erase, EC);
        chk(w_prog == 0 && w_reads == 2, "R8 program skipped", {w_prog, w_reads}, 2);
        exp_mem = 33'h20;
      end else begin
        chk(w_erase == EC, "R5 erase length", w_erase, EC);
        chk(w_prog == PC, "R5 program length", w_prog, PC);
        chk(w_reads == 3, "R4 three reads", w_reads, 3);
        chk(w_wd_bad == 0, "R6 program word", w_wd_bad, 0);
        exp_mem = {t.lock, t.data};
        if (t.fault == 2'd2) exp_mem[31] = 1'b0;
        if (t.fault == 2'd3) exp_mem[0]  = 1'b1;
      end
      chk(mem[t.addr] == exp_mem, "R4 R9 array word", mem[t.addr], exp_mem);
      // R10 mode persists, then cleared by a new command
      repeat (6) @(negedge clk);
      chk(tx_mode_o == t.exp_mode, "R10 mode held", tx_mode_o, t.exp_mode);
      new_cmd_i = 1;
      @(negedge clk);
      new_cmd_i = 0;
      chk(tx_mode_o == 0, "R10 new command clears", tx_mode_o, 0);
      fault = 0;
    end

    // R11 and R10: start and new command while busy are ignored
    mem[1] = {1'b0, OLD};
    mem[2] = {1'b0, OLD};
    do_start(3'd1, 32'hCAFE_0001, 1'b0);
    start_i = 1; new_cmd_i = 1; blk_addr_i = 3'd2; blk_data_i = 32'h1111_1111; blk_lock_i = 1;
    @(negedge clk);
    start_i = 0; new_cmd_i = 0;
    watch({1'b0, 32'hCAFE_0001});
    chk(w_wd_bad == 0, "R11 captured word kept", w_wd_bad, 0);
    chk(tx_mode_o == 2'd1 && tx_blk_o == 3'd1, "R11 R10 result of first start",
        {tx_mode_o, tx_blk_o}, {2'd1, 3'd1});
    chk(mem[2] == {1'b0, OLD}, "R11 other block untouched", mem[2], {1'b0, OLD});
    chk(mem[1] == {1'b0, 32'hCAFE_0001}, "R11 first block written", mem[1], {1'b0, 32'hCAFE_0001});

    // R10 start while idle with a mode shown: mode clears on the next edge
    do_start(3'd1, 32'h0000_00FF, 1'b0);
    chk(tx_mode_o == 0 && busy_o == 1, "R12 new start clears mode", {tx_mode_o, busy_o}, 1);
    watch({1'b0, 32'h0000_00FF});
    chk(tx_mode_o == 2'd1, "R7 second cycle result", tx_mode_o, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule